// File: doc/BRIEF.md
# Quad DAC Serial Command Front End

This block is the digital side of a four-channel digital-to-analog converter that listens as a serial-peripheral-interface target. A host sends 24-bit frames, most significant bit first, while chip select is held low. When chip select rises after exactly 24 clock pulses, the frame is decoded. Its top four bits give an operation code. The next four bits give a channel select in which each bit picks one channel, so several channels can be chosen at once. The low sixteen bits carry a left-justified data value.

Each channel has a staged input register and a live output code register. The outputs also include a two-bit power-state field per channel and one reference-source select bit. An external update pulse copies staged values to the outputs on every channel that is not masked. A readback operation arms the block so that, during the frame that follows, the staged value of one channel is shifted back to the host on the serial data output.

The serial pins are oversampled by the system clock through two-flop synchronizers. SCLK must therefore stay at least six system clocks in each phase.

Top module: `qdac_spi_front`

## Requirements
- R1: A frame is accepted only if exactly 24 rising SCLK edges occur while chip select is low. Bits 23:20 are the operation, bits 19:16 the channel select (bit n selects channel n), and bits 15:0 the data. A frame of any other length changes no state.
- R2: Operation 1 loads the input register of every selected channel, including all four for select 0xF. Output codes stay unchanged.
- R3: Operation 2 copies the input register to the output code of each selected channel only.
- R4: Operation 3 loads both the input register and the output code of each selected channel with the frame value.
- R5: A stored code is data bits 15 down to 16-RES_BITS. Data bits below that are discarded (with RES_BITS=12, data 0xABCD stores 0xABC).
- R6: Operation 4 sets the power state of channel n from data bits [2n+1:2n] for all four channels, regardless of the select field. The encodings are 0 normal, 1 one-kilohm pull-down, 2 hundred-kilohm pull-down, 3 high impedance.
- R7: Operation 5 stores data bits 3:0 as an update mask. A high `upd_strobe` copies input to output code on each channel whose mask bit is 0. Masked channels keep their code.
- R8: Operation 6 clears all input registers, output codes, power states, the mask and any armed readback. The reference select is kept.
- R9: Operation 7 sets `ref_ext_o` to data bit 0 (0 internal, 1 external).
- R10: Operation 9 with a single-bit select arms readback. During the next frame only, MISO returns 24 bits MSB first: eight zeros, then the selected input register left-justified in 16 bits. With any other select, or in any later frame, the returned bits are zero. MISO is first valid after chip select falls and changes after falling SCLK edges.
- R11: MISO is high impedance while chip select is high.
- R12: Operations 0, 8 and 10 through 15 change no state.
- R13: After reset all codes, power states, the mask and the reference select are zero, and MISO is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, high impedance when not selected |
| upd_strobe | input | 1 | Synchronous pulse that copies input to output on unmasked channels |
| dac_code_o | output | 4*RES_BITS | Output codes, channel n at [n*RES_BITS +: RES_BITS] |
| pd_mode_o | output | 8 | Power state, channel n at [2n+1:2n] |
| ref_ext_o | output | 1 | Reference source select |

## Verification
Directed frames drive single, multiple and all-channel selects, so a decoder that ignores or inverts select bits is caught. Frames of 23 and 25 bits tell a strict length check apart from one that only looks for a count of at least 24. A mask followed by a strobe separates masked channels from unmasked ones. Readback is tried with a single-bit select, a multi-bit select, and again one frame later, which shows whether arming is consumed. Random frames over all sixteen operations, with occasional length errors and strobes, are compared against a bench model after every frame.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  localparam int FRAME_BITS = 24;
  localparam int OP_W       = 4;
  localparam int SEL_W      = 4;
  localparam int DATA_W     = 16;
  localparam int NUM_CH     = SEL_W;
  localparam int PD_W       = 2;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 4'd0,
    OP_WR_IN  = 4'd1,
    OP_UPD    = 4'd2,
    OP_WR_UPD = 4'd3,
    OP_PWRDN  = 4'd4,
    OP_MASK   = 4'd5,
    OP_RESET  = 4'd6,
    OP_REF    = 4'd7,
    OP_CHAIN  = 4'd8,
    OP_RDBK   = 4'd9
  } op_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] data;
  } frame_t;

  // true when exactly one select bit is set
  function automatic logic sel_single(input logic [SEL_W-1:0] s);
    return (s != '0) && ((s & (s - 1'b1)) == '0);
  endfunction

  // power-state field of channel n inside the data word
  function automatic logic [PD_W-1:0] pd_field(input logic [DATA_W-1:0] d, input int n);
    return d[PD_W*n +: PD_W];
  endfunction

  // word returned on MISO for a readback
  function automatic logic [FRAME_BITS-1:0] rb_frame(input logic [DATA_W-1:0] v);
    return {{(FRAME_BITS-DATA_W){1'b0}}, v};
  endfunction

endpackage

// File: rtl/qdac_spi_shifter.sv
module qdac_spi_shifter
  import qdac_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  mosi,
  input  logic [FRAME_BITS-1:0] tx_word,
  output logic [FRAME_BITS-1:0] frame_word,
  output logic                  frame_ok,
  output logic                  frame_start,
  output logic                  miso_bit,
  output logic                  miso_oe
);

  logic [1:0] sclk_m, cs_m, mosi_m;
  logic       sclk_q, cs_q;
  logic       sclk_s, cs_s, mosi_s;
  logic       sclk_rise, sclk_fall, cs_rise;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] rx_sh, tx_sh;

  assign sclk_s = sclk_m[1];
  assign cs_s   = cs_m[1];
  assign mosi_s = mosi_m[1];

  // named edge events
  assign sclk_rise   = sclk_s & ~sclk_q & ~cs_s;
  assign sclk_fall   = ~sclk_s & sclk_q & ~cs_s;
  assign cs_rise     = cs_s & ~cs_q;
  assign frame_start = ~cs_s & cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_m <= '0;
      cs_m   <= '1;
      mosi_m <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_m <= {sclk_m[0], sclk};
      cs_m   <= {cs_m[0], cs_n};
      mosi_m <= {mosi_m[0], mosi};
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
    end
  end

  // receive path with saturating length counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      frame_ok   <= 1'b0;
      frame_word <= '0;
    end else begin
      frame_ok <= cs_rise && (bit_cnt == CNT_W'(FRAME_BITS));
      if (cs_rise) frame_word <= rx_sh;
      if (frame_start) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        rx_sh <= {rx_sh[FRAME_BITS-2:0], mosi_s};
        if (bit_cnt != CNT_W'(FRAME_BITS + 1)) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // transmit path: load at select, shift after falling edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      miso_oe <= 1'b0;
    end else begin
      miso_oe <= ~cs_s;
      if (frame_start)    tx_sh <= tx_word;
      else if (sclk_fall) tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign miso_bit = tx_sh[FRAME_BITS-1];

  AST_RX_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(rx_sh)); // R1
  AST_MISO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !miso_oe); // R11
  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> $past(bit_cnt) == CNT_W'(FRAME_BITS)); // R1

endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_ok,
  input  logic [FRAME_BITS-1:0]   frame_word,
  input  logic                    frame_start,
  input  logic                    upd_strobe,
  output logic                    clr_all,
  output logic [NUM_CH-1:0]       wr_in,
  output logic [NUM_CH-1:0]       ld_direct,
  output logic [NUM_CH-1:0]       ld_from_in,
  output logic [PD_W*NUM_CH-1:0]  pd_q,
  output logic                    ref_q,
  output logic                    rb_armed,
  output logic [SEL_W-1:0]        rb_sel
);

  frame_t            f;
  op_e               op;
  logic [NUM_CH-1:0] mask_q;
  logic              is_wr, is_wr_upd, is_upd;

  assign f  = frame_t'(frame_word);
  assign op = op_e'(f.op);

  assign clr_all   = frame_ok && (op == OP_RESET);
  assign is_wr     = frame_ok && ((op == OP_WR_IN) || (op == OP_WR_UPD));
  assign is_wr_upd = frame_ok && (op == OP_WR_UPD);
  assign is_upd    = frame_ok && (op == OP_UPD);

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_strobe
      assign wr_in[n]      = is_wr && f.sel[n];
      assign ld_direct[n]  = is_wr_upd && f.sel[n];
      assign ld_from_in[n] = (is_upd && f.sel[n]) || (upd_strobe && !mask_q[n]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q     <= '0;
      mask_q   <= '0;
      ref_q    <= 1'b0;
      rb_armed <= 1'b0;
      rb_sel   <= '0;
    end else begin
      if (frame_start) rb_armed <= 1'b0;
      if (frame_ok) begin
        case (op)
          OP_PWRDN: for (int n = 0; n < NUM_CH; n++) pd_q[PD_W*n +: PD_W] <= pd_field(f.data, n);
          OP_MASK:  mask_q <= f.data[NUM_CH-1:0];
          OP_RESET: begin
            pd_q     <= '0;
            mask_q   <= '0;
            rb_armed <= 1'b0;
            rb_sel   <= '0;
          end
          OP_REF:   ref_q <= f.data[0];
          OP_RDBK: begin
            rb_armed <= sel_single(f.sel);
            rb_sel   <= f.sel;
          end
          default: ;
        endcase
      end
    end
  end

  AST_PD_BY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_q) |-> $past(frame_ok)); // R6
  AST_MASK_BY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask_q) |-> $past(frame_ok)); // R7
  AST_RB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rb_armed |-> $onehot(rb_sel)); // R10
  AST_RB_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_start) |-> !rb_armed); // R10

endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                wr_in,
  input  logic                ld_direct,
  input  logic                ld_from_in,
  input  logic [RES_BITS-1:0] din,
  output logic [RES_BITS-1:0] in_q,
  output logic [RES_BITS-1:0] dac_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else if (clr) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      if (wr_in)           in_q  <= din;
      if (ld_direct)       dac_q <= din;
      else if (ld_from_in) dac_q <= in_q;
    end
  end

  AST_IN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_q) |-> ($past(wr_in) || $past(clr))); // R2
  AST_DAC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_q) |-> (($past(clr) && dac_q == '0) || dac_q == $past(in_q) || dac_q == $past(din))); // R3

endmodule

// File: rtl/qdac_spi_front.sv
module qdac_spi_front
  import qdac_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         spi_sclk,
  input  logic                         spi_cs_n,
  input  logic                         spi_mosi,
  output logic                         spi_miso,
  input  logic                         upd_strobe,
  output logic [NUM_CH*RES_BITS-1:0]   dac_code_o,
  output logic [PD_W*NUM_CH-1:0]       pd_mode_o,
  output logic                         ref_ext_o
);

  localparam int PAD_BITS = DATA_W - RES_BITS;

  logic [FRAME_BITS-1:0] frame_word, tx_word;
  logic                  frame_ok, frame_start, miso_bit, miso_oe;
  logic                  clr_all, rb_armed;
  logic [NUM_CH-1:0]     wr_in, ld_direct, ld_from_in;
  logic [SEL_W-1:0]      rb_sel;
  logic [RES_BITS-1:0]   din;
  logic [RES_BITS-1:0]   in_q  [NUM_CH];
  logic [RES_BITS-1:0]   dac_q [NUM_CH];
  logic [DATA_W-1:0]     rb_just [NUM_CH];
  logic [DATA_W-1:0]     rb_pick;

  qdac_spi_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_word(tx_word), .frame_word(frame_word), .frame_ok(frame_ok),
    .frame_start(frame_start), .miso_bit(miso_bit), .miso_oe(miso_oe)
  );

  qdac_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_word(frame_word),
    .frame_start(frame_start), .upd_strobe(upd_strobe), .clr_all(clr_all),
    .wr_in(wr_in), .ld_direct(ld_direct), .ld_from_in(ld_from_in),
    .pd_q(pd_mode_o), .ref_q(ref_ext_o), .rb_armed(rb_armed), .rb_sel(rb_sel)
  );

  // left-justified data field keeps its top RES_BITS
  assign din = frame_word[DATA_W-1 -: RES_BITS];

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      qdac_chan #(.RES_BITS(RES_BITS)) u_chan (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .wr_in(wr_in[n]),
        .ld_direct(ld_direct[n]), .ld_from_in(ld_from_in[n]), .din(din),
        .in_q(in_q[n]), .dac_q(dac_q[n])
      );
      assign dac_code_o[n*RES_BITS +: RES_BITS] = dac_q[n];
      assign rb_just[n] = DATA_W'(in_q[n]) << PAD_BITS;
    end
  endgenerate

  always_comb begin
    rb_pick = '0;
    for (int n = 0; n < NUM_CH; n++) if (rb_sel[n]) rb_pick = rb_pick | rb_just[n];
  end

  assign tx_word  = rb_armed ? rb_frame(rb_pick) : '0;
  assign spi_miso = miso_oe ? miso_bit : 1'bz;

  AST_CODE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code_o) |-> ($past(frame_ok) || $past(upd_strobe))); // R7
  AST_TX_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_armed |-> tx_word == '0); // R10

endmodule

// File: tb/qdac_spi_front_bench.sv
`timescale 1ns/1ps
module qdac_spi_front_bench;

  localparam int RES  = 12;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, strobe = 1'b0;
  wire  miso;
  logic [4*RES-1:0] dac_code;
  logic [7:0]       pd_mode;
  logic             ref_ext;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [RES-1:0] m_in [4];
  logic [RES-1:0] m_dac [4];
  logic [7:0]     m_pd;
  logic [3:0]     m_mask;
  logic           m_ref, m_armed;
  logic [3:0]     m_sel;

  always #10 clk = ~clk;

  qdac_spi_front #(.RES_BITS(RES)) u_qdac_spi_front (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .upd_strobe(strobe), .dac_code_o(dac_code),
    .pd_mode_o(pd_mode), .ref_ext_o(ref_ext)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [RES-1:0] code_of(input logic [15:0] d);
    return RES'(d / (16'd1 << (16 - RES)));
  endfunction

  function automatic bit one_bit(input logic [3:0] s);
    return $countones(s) == 1;
  endfunction

  function automatic logic [4*RES-1:0] pack_dac();
    logic [4*RES-1:0] v = '0;
    for (int n = 0; n < 4; n++) v[n*RES +: RES] = m_dac[n];
    return v;
  endfunction

  task automatic model_reset();
    for (int n = 0; n < 4; n++) begin m_in[n] = '0; m_dac[n] = '0; end
    m_pd = '0; m_mask = '0; m_armed = 0; m_sel = '0;
  endtask

  task automatic model_frame(input logic [23:0] w);
    logic [3:0] op = w[23:20];
    logic [3:0] sel = w[19:16];
    logic [15:0] d = w[15:0];
    case (op)
      4'd1: for (int n = 0; n < 4; n++) if (sel[n]) m_in[n] = code_of(d);
      4'd2: for (int n = 0; n < 4; n++) if (sel[n]) m_dac[n] = m_in[n];
      4'd3: for (int n = 0; n < 4; n++) if (sel[n]) begin m_in[n] = code_of(d); m_dac[n] = code_of(d); end
      4'd4: m_pd = d[7:0];
      4'd5: m_mask = d[3:0];
      4'd6: model_reset();
      4'd7: m_ref = d[0];
      4'd9: begin m_armed = one_bit(sel); m_sel = sel; end
      default: ;
    endcase
  endtask

  task automatic check_state(input string tag);
    check(dac_code === pack_dac(), {tag, " codes"}, 64'(dac_code), 64'(pack_dac()));
    check(pd_mode === m_pd, {tag, " power"}, 64'(pd_mode), 64'(m_pd));
    check(ref_ext === m_ref, {tag, " ref"}, 64'(ref_ext), 64'(m_ref));
  endtask

  // send nbits of w; returns first 24 bits read from MISO and expected readback
  task automatic send(input logic [23:0] w, input int nbits, output logic [23:0] rx, output logic [23:0] exp_rx);
    exp_rx = '0;
    if (m_armed) begin
      for (int n = 0; n < 4; n++) if (m_sel[n]) exp_rx = {8'h00, m_in[n], {(16-RES){1'b0}}};
    end
    m_armed = 0;
    rx = '0;
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? w[23-i] : 1'b0;
      wclk(HALF);
      if (i < 24) rx[23-i] = miso;
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
    wclk(HALF);
    cs_n = 1'b1;
    wclk(10);
    if (nbits == 24) model_frame(w);
  endtask

  task automatic frame_chk(input logic [23:0] w, input int nbits, input string tag);
    logic [23:0] rx, erx;
    send(w, nbits, rx, erx);
    check_state(tag);
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1;
    wclk(1);
    strobe = 1'b0;
    wclk(3);
    for (int n = 0; n < 4; n++) if (!m_mask[n]) m_dac[n] = m_in[n];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] rx, erx;
    void'($urandom(32'd20240611));
    model_reset();
    m_ref = 0;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);

    check_state("R13 reset");
    check(miso === 1'bz, "R11 R13 idle miso", 64'(miso), 64'h0);

    frame_chk(24'h1_1_ABCD, 24, "R2 single write");
    frame_chk(24'h2_1_0000, 24, "R3 R5 update ch0");
    check(dac_code[RES-1:0] === 12'hABC, "R5 justify", 64'(dac_code[RES-1:0]), 64'hABC);
    frame_chk(24'h1_F_1234, 24, "R2 all write");
    frame_chk(24'h2_6_0000, 24, "R3 update ch1 ch2");
    frame_chk(24'h3_5_FFFF, 24, "R4 multi write-update");
    frame_chk(24'h3_F_5A5F, 24, "R4 all write-update");
    frame_chk(24'h3_F_0123, 23, "R1 short frame");
    frame_chk(24'h3_F_0123, 25, "R1 long frame");
    frame_chk(24'h4_0_00E4, 24, "R6 power states");
    frame_chk(24'h4_3_0000, 24, "R6 power normal");
    frame_chk(24'h5_0_0005, 24, "R7 mask");
    frame_chk(24'h1_F_9870, 24, "R7 stage");
    pulse_strobe();
    check_state("R7 strobe");
    frame_chk(24'h7_0_0001, 24, "R9 ref ext");
    frame_chk(24'h7_0_0000, 24, "R9 ref int");
    frame_chk(24'h7_0_0001, 24, "R9 ref ext");

    frame_chk(24'h9_4_0000, 24, "R10 arm");
    send(24'h0_0_0000, 24, rx, erx);
    check(rx === erx && erx != 0, "R10 readback", 64'(rx), 64'(erx));
    check(miso === 1'bz, "R11 miso after frame", 64'(miso), 64'h0);
    send(24'h0_0_0000, 24, rx, erx);
    check(rx === 24'h0, "R10 single frame only", 64'(rx), 64'h0);
    frame_chk(24'h9_3_0000, 24, "R10 arm multi");
    send(24'h0_0_0000, 24, rx, erx);
    check(rx === 24'h0, "R10 multi select zero", 64'(rx), 64'h0);

    frame_chk(24'h8_F_FFFF, 24, "R12 op8");
    for (int op = 10; op < 16; op++) frame_chk({4'(op), 4'hF, 16'hFFFF}, 24, "R12 unused op");
    frame_chk(24'h0_F_FFFF, 24, "R12 nop");

    frame_chk(24'h6_0_0000, 24, "R8 reset op");
    pulse_strobe();
    check_state("R8 mask cleared");

    for (int k = 0; k < 150; k++) begin
      logic [23:0] w = {4'($urandom % 16), 4'($urandom % 16), 16'($urandom)};
      int r = $urandom % 10;
      int nb = (r == 0) ? 23 : (r == 1) ? 25 : 24;
      if (($urandom % 3) == 0 && w[23:20] == 4'd6) w[23:20] = 4'd3;
      send(w, nb, rx, erx);
      if (nb >= 24) check(rx === erx, "R10 random readback", 64'(rx), 64'(erx));
      check_state("R1 R2 R3 R4 R6 R9 R12 random");
      if (($urandom % 5) == 0) begin
        pulse_strobe();
        check_state("R7 random strobe");
      end
    end
    check(miso === 1'bz, "R11 final idle", 64'(miso), 64'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule